// File: doc/BRIEF.md
# Dual-Channel Staged Gain Register File

This block is the serial-programmable register set for a two-channel gain stage. A host writes an attenuation code for each channel through a four-wire serial port. The code goes into a staging register first. A channel-control register then decides when each staged code reaches the parallel gain bus that the analog path actually uses.

With the default control value, each channel follows its own staging register as soon as that register is written. If a channel's live bit is cleared, that channel's applied gain is frozen while its staging register can still be loaded. Setting the live bits again later moves both channels to their new codes in the same clock cycle. A separate select bit makes channel A's staged code drive both outputs. A power-control register is also in the block. Its two low bits are unused and always read back as zero.

The serial inputs are brought into the system clock domain by synchronisers. A write is committed only when chip select goes high at the end of a complete frame. Every implemented register can be read back over the same port.

Top module: `stagedGainRegs`

## Requirements
- R1: After reset, both staging registers and both applied gains are 0x00, channel control reads 0x03 and power control reads 0x00.
- R2: A frame is 16 bits, SPI mode 0, MSB first. Bit 15 is 1 for a read and 0 for a write. Bits 14:12 are ignored. Bits 11:8 are the register address, MSB first. Bits 7:0 are data.
- R3: A write takes effect only when chip select rises after exactly 16 clock bits. A frame with fewer or more bits changes nothing.
- R4: During the data phase of a read, MISO carries the addressed register's contents MSB first. Staging A is at address 3, staging B at address 4, power control at address 2 and channel control at address 5.
- R5: Addresses other than 2, 3, 4 and 5 read back as 0x00. Writes to them change no register and no output.
- R6: When the channel's live bit is set (bit 0 for A, bit 1 for B) and bit 2 is clear, writing that channel's staging register updates its applied gain.
- R7: When a channel's live bit is clear and bit 2 is clear, its applied gain holds while its staging register takes new writes.
- R8: If both channels are staged with control 0x00 and control is then written to 0x03, both applied gains take their staged values in the same clock cycle.
- R9: When control bit 2 is set, both applied gains follow staging A regardless of bits 0 and 1. Staging B is kept for later use.
- R10: Power control bits 7:2 are writable and appear on the powerCtl output. Bits 1:0 always read and output as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spiSclk | input | 1 | Serial clock from the host (asynchronous) |
| spiCsN | input | 1 | Active-low chip select (asynchronous) |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial read data to the host, 0 while deselected |
| gainA | output | 8 | Applied attenuation code, channel A |
| gainB | output | 8 | Applied attenuation code, channel B |
| powerCtl | output | 8 | Power-control register, low two bits forced to 0 |

## Verification
The bench uses the default parameters: a two-stage synchroniser, a three-bit reserved field, an 8-bit data path, and the power register at 2, channel control at 5 and staging at 3 and 4. The 16-bit frame makes it possible to send frames that are one bit short and one bit long, and to set the reserved bits on a write. An all-ones power write shows that the dead low bits stay at zero. With a serial half-period of eight system clocks, the bench can poll every clock cycle after a commit to check that both channels change on the same edge.

// File: rtl/gainRegsPkg.sv
package gainRegsPkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [ADDR_W-1:0] rdAddr;
  } regStrobe_t;
endpackage

// File: rtl/bitSync.sv
module bitSync #(
  parameter int            STAGES    = 2,
  parameter int            WIDTH     = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= din;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spiFrameCtl.sv
module spiFrameCtl
  import gainRegsPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RSV_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclkRaw,
  input  logic              csNRaw,
  input  logic              mosiRaw,
  input  logic [DATA_W-1:0] rdData,
  output regStrobe_t        strobe,
  output logic              miso
);
  localparam int HDR_LEN   = 1 + RSV_W + ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);

  logic sclkS, csNS, mosiS;
  logic sclkQ, csNQ;
  logic sclkRise, sclkFall, csRise;
  logic [CNT_W-1:0]     bitCnt;
  logic [FRAME_LEN-1:0] shiftIn;
  logic [DATA_W-1:0]    shiftOut;

  bitSync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sclkRaw, csNRaw, mosiRaw}),
    .dout({sclkS, csNS, mosiS})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ <= 1'b0;
      csNQ  <= 1'b1;
    end else begin
      sclkQ <= sclkS;
      csNQ  <= csNS;
    end
  end

  assign sclkRise = sclkS & ~sclkQ & ~csNS;
  assign sclkFall = ~sclkS & sclkQ & ~csNS;
  assign csRise   = csNS & ~csNQ;

  // Bit counter saturates one past a full frame, so that overlong frames can be told apart
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt  <= '0;
      shiftIn <= '0;
    end else if (csNS) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      shiftIn <= {shiftIn[FRAME_LEN-2:0], mosiS};
      if (bitCnt != CNT_OVER) bitCnt <= bitCnt + 1'b1;
    end
  end

  // Commit a write only at the end of an exact-length frame with the read flag clear
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe.wrEn   <= 1'b0;
      strobe.wrAddr <= '0;
      strobe.wrData <= '0;
    end else begin
      strobe.wrEn   <= csRise && (bitCnt == CNT_FULL) && !shiftIn[FRAME_LEN-1];
      strobe.wrAddr <= shiftIn[DATA_W +: ADDR_W];
      strobe.wrData <= shiftIn[DATA_W-1:0];
    end
  end

  assign strobe.rdAddr = shiftIn[ADDR_W-1:0];

  // Read data: load after the last header bit, shift on each later falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftOut <= '0;
    end else if (sclkFall) begin
      if (bitCnt == CNT_HDR) shiftOut <= rdData;
      else if (bitCnt > CNT_HDR) shiftOut <= {shiftOut[DATA_W-2:0], 1'b0};
    end
  end

  assign miso = ~csNS & shiftOut[DATA_W-1];

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> !strobe.wrEn); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= CNT_OVER); // R3
  AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    csNS |=> (bitCnt == '0)); // R2
endmodule

// File: rtl/gainRegFile.sv
module gainRegFile
  import gainRegsPkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_PWR      = 4'd2,
  parameter logic [ADDR_W-1:0] ADDR_ATT_A    = 4'd3,
  parameter logic [ADDR_W-1:0] ADDR_ATT_B    = 4'd4,
  parameter logic [ADDR_W-1:0] ADDR_CTL      = 4'd5,
  parameter logic [DATA_W-1:0] CTL_RESET     = 8'h03,
  parameter logic [DATA_W-1:0] PWR_RESET     = 8'h00,
  parameter int                PWR_DEAD_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] gainA,
  output logic [DATA_W-1:0] gainB,
  output logic [DATA_W-1:0] pwrOut
);
  localparam int CTL_A_BOTH = 2;
  localparam logic [DATA_W-1:0] PWR_MASK =
    {{(DATA_W-PWR_DEAD_BITS){1'b1}}, {PWR_DEAD_BITS{1'b0}}};

  logic [DATA_W-1:0] stage  [NUM_CH];
  logic [DATA_W-1:0] gain   [NUM_CH];
  logic [DATA_W-1:0] ctlReg;
  logic [DATA_W-1:0] pwrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlReg <= CTL_RESET;
      pwrReg <= PWR_RESET & PWR_MASK;
    end else if (strobe.wrEn) begin
      if (strobe.wrAddr == ADDR_CTL) ctlReg <= strobe.wrData;
      if (strobe.wrAddr == ADDR_PWR) pwrReg <= strobe.wrData & PWR_MASK;
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      localparam logic [ADDR_W-1:0] MY_ADDR = (ch == 0) ? ADDR_ATT_A : ADDR_ATT_B;
      logic              liveEn;
      logic [DATA_W-1:0] srcVal;

      always_ff @(posedge clk) begin
        if (rst) stage[ch] <= '0;
        else if (strobe.wrEn && strobe.wrAddr == MY_ADDR) stage[ch] <= strobe.wrData;
      end

      // A-drives-both has priority over the per-channel live bits
      assign liveEn = ctlReg[CTL_A_BOTH] | ctlReg[ch];
      assign srcVal = ctlReg[CTL_A_BOTH] ? stage[0] : stage[ch];

      always_ff @(posedge clk) begin
        if (rst) gain[ch] <= '0;
        else if (liveEn) gain[ch] <= srcVal;
      end

      AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctlReg[CTL_A_BOTH] && !ctlReg[ch]) |=> $stable(gain[ch])); // R7
      AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!ctlReg[CTL_A_BOTH] && ctlReg[ch]) |=> (gain[ch] == $past(stage[ch]))); // R6
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (strobe.rdAddr == ADDR_PWR)   rdData = pwrReg;
    if (strobe.rdAddr == ADDR_ATT_A) rdData = stage[0];
    if (strobe.rdAddr == ADDR_ATT_B) rdData = stage[1];
    if (strobe.rdAddr == ADDR_CTL)   rdData = ctlReg;
  end

  assign gainA  = gain[0];
  assign gainB  = gain[1];
  assign pwrOut = pwrReg;

  AST_A_DRIVES_BOTH: assert property (@(posedge clk) disable iff (rst)
    ctlReg[CTL_A_BOTH] |=> (gainA == gainB)); // R9
  AST_JOINT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (ctlReg[2:0] == 3'b011) |=> (gainA == $past(stage[0]) && gainB == $past(stage[1]))); // R8
  AST_PWR_DEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> (pwrOut[PWR_DEAD_BITS-1:0] == '0)); // R10
endmodule

// File: rtl/stagedGainRegs.sv
module stagedGainRegs
  import gainRegsPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RSV_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [DATA_W-1:0] gainA,
  output logic [DATA_W-1:0] gainB,
  output logic [DATA_W-1:0] powerCtl
);
  regStrobe_t        strobe;
  logic [DATA_W-1:0] rdData;

  spiFrameCtl #(.SYNC_STAGES(SYNC_STAGES), .RSV_W(RSV_W)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .sclkRaw(spiSclk),
    .csNRaw (spiCsN),
    .mosiRaw(spiMosi),
    .rdData (rdData),
    .strobe (strobe),
    .miso   (spiMiso)
  );

  gainRegFile u_regs (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .rdData(rdData),
    .gainA (gainA),
    .gainB (gainB),
    .pwrOut(powerCtl)
  );
endmodule

// File: tb/sim_stagedGainRegs.sv
module sim_stagedGainRegs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMiso;
  logic [7:0] gainA, gainB, powerCtl;
  int nChecks = 0, nFails = 0;
  bit done = 0;
  localparam int HALF = 8;

  always #5 clk = ~clk;

  stagedGainRegs u0 (
    .clk(clk), .rst(rst), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .gainA(gainA), .gainB(gainB), .powerCtl(powerCtl)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] word, input int nbits, input int tail, output logic [7:0] rx);
    rx = '0;
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spiMosi = (i < 16) ? word[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b1;
      if (i >= 8 && i < 16) rx[15-i] = spiMiso;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (tail) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] addr, input logic [7:0] data);
    logic [7:0] rx;
    xfer({1'b0, 3'b000, addr, data}, 16, 12, rx);
  endtask

  task automatic rd(input logic [3:0] addr, output logic [7:0] data);
    xfer({1'b1, 3'b000, addr, 8'h00}, 16, 12, data);
  endtask

  task automatic tReset;
    logic [7:0] v;
    check(gainA == 8'h00, "R1 gainA reset", gainA, 8'h00);
    check(gainB == 8'h00, "R1 gainB reset", gainB, 8'h00);
    check(powerCtl == 8'h00, "R1 power reset", powerCtl, 8'h00);
    rd(4'd5, v); check(v == 8'h03, "R1 R4 ctl reset readback", v, 8'h03);
    rd(4'd3, v); check(v == 8'h00, "R1 stage A reset", v, 8'h00);
    rd(4'd4, v); check(v == 8'h00, "R1 stage B reset", v, 8'h00);
  endtask

  task automatic tLive;
    logic [7:0] v;
    wr(4'd3, 8'h2A);
    check(gainA == 8'h2A, "R6 gainA live", gainA, 8'h2A);
    check(gainB == 8'h00, "R6 gainB untouched", gainB, 8'h00);
    wr(4'd4, 8'h15);
    check(gainB == 8'h15, "R6 gainB live", gainB, 8'h15);
    rd(4'd3, v); check(v == 8'h2A, "R4 read stage A", v, 8'h2A);
    rd(4'd4, v); check(v == 8'h15, "R4 read stage B", v, 8'h15);
  endtask

  task automatic tHold;
    logic [7:0] v;
    wr(4'd5, 8'h01);
    wr(4'd4, 8'h40);
    check(gainB == 8'h15, "R7 gainB held", gainB, 8'h15);
    rd(4'd4, v); check(v == 8'h40, "R7 stage B loaded while held", v, 8'h40);
    wr(4'd3, 8'h11);
    check(gainA == 8'h11, "R6 gainA still live", gainA, 8'h11);
  endtask

  task automatic tCommit;
    logic [7:0] rx;
    logic [7:0] oldA, oldB;
    bit seen;
    wr(4'd5, 8'h00);
    wr(4'd3, 8'h77);
    wr(4'd4, 8'h88);
    check(gainA == 8'h11, "R7 gainA held at 0x00", gainA, 8'h11);
    check(gainB == 8'h15, "R7 gainB held at 0x00", gainB, 8'h15);
    oldA = gainA; oldB = gainB; seen = 0;
    xfer({1'b0, 3'b000, 4'd5, 8'h03}, 16, 0, rx);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (!seen && (gainA != oldA || gainB != oldB)) begin
        seen = 1;
        check(gainA == 8'h77, "R8 gainA in commit cycle", gainA, 8'h77);
        check(gainB == 8'h88, "R8 gainB in commit cycle", gainB, 8'h88);
      end
    end
    check(seen, "R8 commit observed", gainA, 8'h77);
  endtask

  task automatic tBoth;
    logic [7:0] v;
    wr(4'd5, 8'h07);
    check(gainB == 8'h77, "R9 B follows A", gainB, 8'h77);
    wr(4'd3, 8'h33);
    check(gainA == 8'h33 && gainB == 8'h33, "R9 both take new A", gainB, 8'h33);
    wr(4'd4, 8'h99);
    check(gainB == 8'h33, "R9 B write not applied", gainB, 8'h33);
    rd(4'd4, v); check(v == 8'h99, "R9 stage B kept", v, 8'h99);
    wr(4'd5, 8'h03);
    check(gainB == 8'h99, "R9 B returns to own stage", gainB, 8'h99);
  endtask

  task automatic tFrames;
    logic [7:0] v, rx;
    xfer({1'b0, 3'b000, 4'd3, 8'h5C}, 12, 12, rx);
    rd(4'd3, v); check(v == 8'h33, "R3 short frame discarded", v, 8'h33);
    check(gainA == 8'h33, "R3 short frame no gain change", gainA, 8'h33);
    xfer({1'b0, 3'b000, 4'd3, 8'h5C}, 17, 12, rx);
    rd(4'd3, v); check(v == 8'h33, "R3 long frame discarded", v, 8'h33);
    xfer({1'b0, 3'b111, 4'd3, 8'hC6}, 16, 12, rx);
    check(gainA == 8'hC6, "R2 reserved bits ignored", gainA, 8'hC6);
    xfer({1'b1, 3'b000, 4'd3, 8'h01}, 16, 12, rx);
    check(rx == 8'hC6, "R2 read frame returns data", rx, 8'hC6);
    check(gainA == 8'hC6, "R2 read frame writes nothing", gainA, 8'hC6);
  endtask

  task automatic tUnimpl;
    logic [7:0] v;
    wr(4'd7, 8'hAB);
    rd(4'd7, v); check(v == 8'h00, "R5 unimplemented reads zero", v, 8'h00);
    rd(4'd0, v); check(v == 8'h00, "R5 address 0 reads zero", v, 8'h00);
    check(gainA == 8'hC6 && gainB == 8'h99, "R5 gains unchanged", gainA, 8'hC6);
    check(powerCtl == 8'h00, "R5 power unchanged", powerCtl, 8'h00);
    rd(4'd5, v); check(v == 8'h03, "R5 ctl unchanged", v, 8'h03);
  endtask

  task automatic tPower;
    logic [7:0] v;
    wr(4'd2, 8'hFF);
    check(powerCtl == 8'hFC, "R10 power output", powerCtl, 8'hFC);
    rd(4'd2, v); check(v == 8'hFC, "R10 power readback", v, 8'hFC);
    wr(4'd2, 8'h03);
    check(powerCtl == 8'h00, "R10 dead bits only", powerCtl, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    tReset();
    tLive();
    tHold();
    tCommit();
    tBoth();
    tFrames();
    tUnimpl();
    tPower();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule